// File: doc/BRIEF.md
# Cascaded Crosspoint Serial Loader

This block programs a chain of serially cascaded 16-by-16 crosspoint switch devices from a host. A request carries one 256-bit connection matrix per device and a clock-divide value. The block shifts all matrices out on a serial data line under a serial clock whose rising edge is the devices' capture edge. It then pulses an active-low parallel-load strobe so that every device latches its new switch settings at the same time. Finally it raises `done` for one cycle.

The request side is a valid/ready port. `req_ready` is high only while the loader is idle. A request transfers on a clock edge where `req_valid` and `req_ready` are both high, and `req_data` and `div_half` are sampled on that edge. For the whole transaction, up to and including the `done` cycle, `req_ready` stays low. Any `req_valid` seen in that time is simply not taken, and no request is stored. The source may hold `req_valid` high and it will be accepted on the first edge after the loader returns to idle.

The shift storage in the devices is dynamic. The divide value is therefore forced into a window (`HALF_MIN`..`HALF_MAX` system clocks per half period) that keeps the serial clock between the minimum and maximum allowed rates. The strobe follows the last bit with no added delay, which meets the latch deadline.

Top module: `xpt_chain_loader`

## Requirements
- R1: `req_ready` is high exactly when the loader is idle. A request is taken on an edge with `req_valid` and `req_ready` both high. Requests presented while busy are ignored and do not change the shifted data or the timing.
- R2: Bit `req_data[d*256 + y*16 + x]` sets the switch at row y, column x of device d, where device 0 is nearest the host and 1 closes the switch. Bits leave in descending index order, from `req_data[NDEV*256-1]` down to `req_data[0]`, so the farthest device and its row 15 / column 15 switch go first.
- R3: Let H be the effective half period and let cycle 0 be the first cycle after acceptance. For each bit b, `sclk` is low during cycles 2Hb..2Hb+H-1 and high during cycles 2Hb+H..2Hb+2H-1.
- R4: `sdata` changes only together with a falling `sclk`, so it is stable across every rising edge. During cycles 2Hb..2Hb+2H-1 it shows bit NDEV*256-1-b.
- R5: H equals `div_half` sampled at acceptance, raised to `HALF_MIN` if below it and lowered to `HALF_MAX` if above it.
- R6: `strobe_n` is low for exactly 2H cycles, starting in cycle 2H·NDEV·256, and `sclk` stays low while it is low.
- R7: `done` is high for exactly one cycle, the cycle in which `strobe_n` returns high. `busy` is high from cycle 0 through that cycle.
- R8: After reset and between transactions, `sclk` is low, `strobe_n` is high, and `busy` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Loader idle, request can be taken |
| req_data | input | NDEV*256 | Connection matrices of all devices |
| div_half | input | DIV_W | Requested serial clock half period in system clocks |
| sclk | output | 1 | Serial clock, capture on rising edge |
| sdata | output | 1 | Serial data to the first device of the chain |
| strobe_n | output | 1 | Active-low parallel-load strobe |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench feeds the serial outputs into a behavioural model of the device chain. It compares the latched matrices with the request, which catches a loader that reverses device order or row/column order because the wrong switches would close. Divide values below and above the window check the clamp: a loader that passes them through would produce a serial clock period the cycle model rejects. Requests arriving mid-transaction and requests held across the `done` cycle check the handshake rule. A loader that restarts or queues such a request would break the cycle-exact comparison of `sdata`, `sclk` and `strobe_n`. A pattern set only at the extreme indices checks that the first and last bits are neither dropped nor duplicated.

// File: rtl/xpt_pkg.sv
package xpt_pkg;
  localparam int unsigned XPT_ROWS     = 16;
  localparam int unsigned XPT_COLS     = 16;
  localparam int unsigned XPT_DEV_BITS = XPT_ROWS * XPT_COLS;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SHIFT  = 2'd1,
    ST_STROBE = 2'd2,
    ST_DONE   = 2'd3
  } xpt_state_e;
endpackage

// File: rtl/xpt_half_tick.sv
module xpt_half_tick #(
  parameter int unsigned HW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [HW-1:0] half,
  output logic          tick
);
  logic [HW-1:0] cnt_q;

  assign tick = en && (cnt_q == half - HW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (!en || tick)   cnt_q <= '0;
    else                    cnt_q <= cnt_q + HW'(1);
  end
endmodule

// File: rtl/xpt_bit_shifter.sv
module xpt_bit_shifter #(
  parameter int unsigned TOTAL = 512
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [TOTAL-1:0] load_data,
  input  logic             advance,
  output logic             sdata,
  output logic             last_bit
);
  localparam int unsigned CW = $clog2(TOTAL);

  logic [TOTAL-1:0] vec_q;
  logic [CW-1:0]    idx_q;

  assign sdata    = vec_q[TOTAL-1];
  assign last_bit = (idx_q == CW'(TOTAL-1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_q <= '0;
      idx_q <= '0;
    end else if (load) begin
      vec_q <= load_data;
      idx_q <= '0;
    end else if (advance) begin
      vec_q <= {vec_q[TOTAL-2:0], 1'b0};
      idx_q <= idx_q + CW'(1);
    end
  end
endmodule

// File: rtl/xpt_seq_fsm.sv
module xpt_seq_fsm
  import xpt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic tick,
  input  logic last_bit,
  output logic accept,
  output logic advance,
  output logic tick_en,
  output logic sclk,
  output logic strobe_n,
  output logic busy,
  output logic done,
  output logic ready
);
  xpt_state_e state_q;
  logic       sclk_q;
  logic       strobe_q;
  logic       strb_half_q;

  assign ready    = (state_q == ST_IDLE);
  assign busy     = !ready;
  assign accept   = ready && req_valid;
  assign tick_en  = (state_q == ST_SHIFT) || (state_q == ST_STROBE);
  assign advance  = (state_q == ST_SHIFT) && tick && sclk_q && !last_bit;
  assign done     = (state_q == ST_DONE);
  assign sclk     = sclk_q;
  assign strobe_n = strobe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      sclk_q      <= 1'b0;
      strobe_q    <= 1'b1;
      strb_half_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (req_valid) state_q <= ST_SHIFT;
        ST_SHIFT: if (tick) begin
          sclk_q <= !sclk_q;
          if (sclk_q && last_bit) begin
            state_q     <= ST_STROBE;
            strobe_q    <= 1'b0;
            strb_half_q <= 1'b0;
          end
        end
        ST_STROBE: if (tick) begin
          if (!strb_half_q) strb_half_q <= 1'b1;
          else begin
            strobe_q <= 1'b1;
            state_q  <= ST_DONE;
          end
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_IDLE_LINES: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |-> (!sclk_q && strobe_q)); // R8
  AST_CLK_QUIET_IN_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe_q |-> !sclk_q); // R6
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7
  AST_DONE_ON_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(strobe_q) |-> done); // R7
  AST_NO_TAKE_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && req_valid && !done) |=> busy); // R1
endmodule

// File: rtl/xpt_chain_loader.sv
module xpt_chain_loader
  import xpt_pkg::*;
#(
  parameter int unsigned NDEV     = 2,
  parameter int unsigned DIV_W    = 16,
  parameter int unsigned HALF_MIN = 5,
  parameter int unsigned HALF_MAX = 1250
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         req_valid,
  output logic                         req_ready,
  input  logic [NDEV*XPT_DEV_BITS-1:0] req_data,
  input  logic [DIV_W-1:0]             div_half,
  output logic                         sclk,
  output logic                         sdata,
  output logic                         strobe_n,
  output logic                         busy,
  output logic                         done
);
  localparam int unsigned TOTAL = NDEV * XPT_DEV_BITS;
  localparam int unsigned HW    = $clog2(HALF_MAX + 1);

  logic          accept, advance, tick_en, tick, last_bit;
  logic [HW-1:0] half_req, half_q;

  always_comb begin
    if (32'(div_half) < HALF_MIN)      half_req = HW'(HALF_MIN);
    else if (32'(div_half) > HALF_MAX) half_req = HW'(HALF_MAX);
    else                               half_req = HW'(div_half);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      half_q <= HW'(HALF_MIN);
    else if (accept) half_q <= half_req;
  end

  xpt_half_tick #(.HW(HW)) i_tick (
    .clk(clk), .rst_n(rst_n), .en(tick_en), .half(half_q), .tick(tick)
  );

  xpt_bit_shifter #(.TOTAL(TOTAL)) i_shift (
    .clk(clk), .rst_n(rst_n), .load(accept), .load_data(req_data),
    .advance(advance), .sdata(sdata), .last_bit(last_bit)
  );

  xpt_seq_fsm i_fsm (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .tick(tick),
    .last_bit(last_bit), .accept(accept), .advance(advance),
    .tick_en(tick_en), .sclk(sclk), .strobe_n(strobe_n), .busy(busy),
    .done(done), .ready(req_ready)
  );

  AST_HALF_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (32'(half_q) >= HALF_MIN && 32'(half_q) <= HALF_MAX)); // R5
  AST_DATA_STEADY_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |-> $stable(sdata)); // R4
  AST_SHIFT_ONLY_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$stable(sdata)) |-> $fell(sclk)); // R4
endmodule

// File: tb/test_xpt_chain_loader.sv
module test_xpt_chain_loader;
  localparam int NDEV = 2;
  localparam int TOTAL = NDEV * 256;
  localparam int HMIN = 5;
  localparam int HMAX = 20; // window scaled down to bound run time

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             req_valid = 1'b0;
  logic             req_ready;
  logic [TOTAL-1:0] req_data = '0;
  logic [15:0]      div_half = '0;
  logic             sclk, sdata, strobe_n, busy, done;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  xpt_chain_loader #(.NDEV(NDEV), .DIV_W(16), .HALF_MIN(HMIN), .HALF_MAX(HMAX)) i_xpt_chain_loader (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_data(req_data), .div_half(div_half), .sclk(sclk), .sdata(sdata),
    .strobe_n(strobe_n), .busy(busy), .done(done)
  );

  always #10 clk = !clk;

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual=%0b expected=%0b", req, cycles, act, exp);
    end
  endtask

  // chain of devices: shifts on rising sclk, latches on strobe release
  logic [TOTAL-1:0] chain = '0;
  logic [TOTAL-1:0] latched = '0;
  always @(posedge sclk) chain = {chain[TOTAL-2:0], sdata};
  always @(posedge strobe_n) latched = chain;

  // inputs as seen at each rising edge
  logic             seen_valid = 1'b0, seen_rst = 1'b0;
  logic [15:0]      seen_div = '0;
  logic [TOTAL-1:0] seen_data = '0;
  always @(posedge clk) begin
    seen_valid <= req_valid;
    seen_div   <= div_half;
    seen_data  <= req_data;
    seen_rst   <= rst_n;
    cycles     <= cycles + 1;
  end

  // behavioural reference
  bit               m_act = 0;
  int               m_k = 0, m_h = HMIN, m_end = 0;
  logic [TOTAL-1:0] m_data = '0;
  always @(negedge clk) begin
    if (rst_n && seen_rst) begin
      if (m_act) begin
        m_k++;
        if (m_k > m_end) m_act = 0;
      end else if (seen_valid) begin
        m_act  = 1;
        m_k    = 0;
        m_h    = (seen_div < HMIN) ? HMIN : (seen_div > HMAX) ? HMAX : int'(seen_div);
        m_end  = 2 * m_h * TOTAL + 2 * m_h;
        m_data = seen_data;
      end
      if (!m_act) begin
        chk("R8 sclk idle", sclk, 1'b0);
        chk("R8 strobe idle", strobe_n, 1'b1);
        chk("R8 busy idle", busy, 1'b0);
        chk("R8 done idle", done, 1'b0);
        chk("R1 ready idle", req_ready, 1'b1);
      end else begin
        chk("R1 ready busy", req_ready, 1'b0);
        chk("R7 busy", busy, 1'b1);
        chk("R7 done", done, logic'(m_k == m_end));
        if (m_k < 2 * m_h * TOTAL) begin
          chk("R3 R5 sclk", sclk, logic'((m_k % (2 * m_h)) >= m_h));
          chk("R2 R4 sdata", sdata, m_data[TOTAL - 1 - m_k / (2 * m_h)]);
          chk("R6 strobe high", strobe_n, 1'b1);
        end else begin
          chk("R6 sclk low", sclk, 1'b0);
          chk("R6 strobe", strobe_n, logic'(m_k == m_end));
        end
        if (m_k == m_end) begin
          checks++;
          if (latched !== m_data) begin
            errors++;
            $display("FAIL R2 latched matrices: actual=%h expected=%h", latched, m_data);
          end
        end
      end
    end
  end

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  task automatic send(input int dv, input logic [TOTAL-1:0] d);
    wait_idle();
    req_valid = 1'b1; div_half = 16'(dv); req_data = d;
    @(negedge clk);
    req_valid = 1'b0; req_data = ~d;
  endtask

  initial begin
    logic [TOTAL-1:0] p;
    repeat (4) @(negedge clk);
    chk("R8 reset sclk", sclk, 1'b0);
    chk("R8 reset strobe", strobe_n, 1'b1);
    chk("R8 reset done", done, 1'b0);
    chk("R1 reset ready", req_ready, 1'b1);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R2 R3: exact window minimum, sparse pattern; R1: requests while busy
    for (int i = 0; i < TOTAL; i++) p[i] = (i % 3 == 0);
    send(5, p);
    repeat (100) @(negedge clk);
    req_valid = 1'b1; req_data = ~p; div_half = 16'd9; // R1 ignored while busy
    repeat (60) @(negedge clk);
    req_valid = 1'b0;

    // R5 low clamp, R2 extreme indices only
    p = '0; p[TOTAL-1] = 1'b1; p[0] = 1'b1;
    send(0, p);

    // R3 mid-window divide, mixed pattern
    for (int i = 0; i < TOTAL; i++) p[i] = i[3] ^ i[8] ^ i[0];
    send(7, p);

    // R5 high clamp, all closed; R1 held valid re-accepted after done
    p = '1;
    send(100, p);
    req_valid = 1'b1; div_half = 16'd6;
    for (int i = 0; i < TOTAL; i++) req_data[i] = (i < 256);
    @(negedge clk);
    while (!done) @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    wait_idle();
    repeat (5) @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule